// File: doc/BRIEF.md
# Nonvolatile Wiper Preset Sequencer

This block holds the digital state of a two-channel digital potentiometer: one 8-bit wiper register per channel, a backup register per channel that stands in for nonvolatile storage, and a bank of fourteen spare user bytes. A serial front end, which is not part of this block, decodes each frame into a single-cycle command strobe with an opcode, an address and a data byte. The sequencer runs the command. Wiper writes take effect at once. Saves, user-byte writes and restores are timed busy operations, and each kind has its own cycle count set by a parameter.

After reset the sequencer copies both backup values into the wipers before it accepts any command. A falling edge on the active-low preset input starts the same copy. The ready output is low during every timed operation and high at all other times. Commands that arrive while the block is busy are dropped and raise a sticky error flag. A lock input turns the two storage-writing commands into no-ops. Any register can be read at any time through a combinational select and data pair.

Top module: `wiper_preset_seq`

## Requirements
- R1: While reset is held and for ALL_CYC cycles after it is released, ready is 0, cmd_err is 0, both wipers read 0 and the backups read INIT0 (0x5A) and INIT1 (0xC3). Ready then rises, and in that same cycle the wipers hold the backup values.
- R2: Opcode 11 writes cmd_data into the wiper selected by cmd_addr[0]. The new value is visible the cycle after the strobe, and ready stays high.
- R3: Opcode 2 holds ready low for SAVE_CYC cycles counted from the strobe edge. When ready rises, the backup of channel cmd_addr[0] holds that channel's wiper value.
- R4: Opcode 3 with cmd_addr below 14 holds ready low for SAVE_CYC cycles, then user byte cmd_addr holds cmd_data. With cmd_addr of 14 or more it has no effect and ready stays high.
- R5: Opcode 8 holds ready low for ALL_CYC cycles, then reloads both wipers from their backups. Opcodes 9 and 10 hold ready low for ONE_CYC cycles, then reload only wiper 0 or only wiper 1 respectively.
- R6: A high-to-low transition of preset_n that is sampled while the block is idle runs the same operation as opcode 8. A transition sampled while the block is busy is dropped. If it falls in the same cycle as a command strobe, the preset wins.
- R7: While nv_lock is 1, opcodes 2 and 3 change no storage and ready stays high.
- R8: A strobe sampled while ready is low, or in the same cycle as an accepted preset edge, has no effect and sets cmd_err. Only reset clears cmd_err.
- R9: rd_data shows a register chosen by rd_sel in the same cycle: 0 and 1 select wiper 0 and 1, 2 and 3 select backup 0 and 1, 4 to 17 select user bytes 0 to 13, and any other value reads 0.
- R10: Opcodes other than 2, 3, 8, 9, 10 and 11 have no effect and leave ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts the power-on restore |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 4 | Command opcode |
| cmd_addr | input | 4 | User byte index; bit 0 selects the channel |
| cmd_data | input | 8 | Data byte for wiper and user writes |
| nv_lock | input | 1 | Blocks writes to backup and user storage |
| preset_n | input | 1 | Active-low preset; a falling edge restores both wipers |
| rd_sel | input | 5 | Readback select |
| rd_data | output | 8 | Selected register contents |
| ready | output | 1 | Low while a timed operation runs |
| cmd_err | output | 1 | Sticky flag for commands that were dropped |

## Verification
The assertions assume that every input changes in step with clk. In particular, preset_n is taken to be already synchronised, so an edge is simply a 1 followed by a 0 in consecutive samples. They also assume the command fields are steady whenever cmd_valid is high. The bench meets these assumptions by changing every input shortly after a rising edge and holding it through the next one. It keeps preset pulses at least one cycle wide, and it raises each strobe for exactly one cycle.

// File: rtl/wps_pkg.sv
package wps_pkg;

   typedef enum logic [3:0] {
      OPC_NOP         = 4'd0,
      OPC_SAVE        = 4'd2,
      OPC_USER_WR     = 4'd3,
      OPC_RESTORE_ALL = 4'd8,
      OPC_RESTORE_0   = 4'd9,
      OPC_RESTORE_1   = 4'd10,
      OPC_WIPER_WR    = 4'd11
   } opcode_e;

   typedef enum logic [2:0] {
      JOB_NONE,
      JOB_SAVE,
      JOB_USER,
      JOB_ALL,
      JOB_ONE
   } job_e;

endpackage

// File: rtl/wps_busy_timer.sv
module wps_busy_timer #(
   parameter int CNT_W     = 5,
   parameter int BOOT_LOAD = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] load,
   output logic             busy,
   output logic             done
);

   if (BOOT_LOAD < 1 || BOOT_LOAD >= (1 << CNT_W)) begin : g_bad_boot
      $error("wps_busy_timer: BOOT_LOAD out of range");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b1;
         cnt  <= CNT_W'(BOOT_LOAD);
      end else if (busy) begin
         if (cnt == CNT_W'(1)) busy <= 1'b0;
         else                  cnt  <= cnt - CNT_W'(1);
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= load;
      end
   end

   assign done = busy && (cnt == CNT_W'(1));

   assert_start_goes_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
   assert_done_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

endmodule

// File: rtl/wps_nv_bank.sv
module wps_nv_bank #(
   parameter int          W      = 8,
   parameter int          USER_N = 14,
   parameter int          UA_W   = 4,
   parameter logic [W-1:0] INIT0  = '0,
   parameter logic [W-1:0] INIT1  = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bk_we,
   input  logic                  bk_ch,
   input  logic [W-1:0]          bk_wdata,
   input  logic                  usr_we,
   input  logic [UA_W-1:0]       usr_addr,
   input  logic [W-1:0]          usr_wdata,
   output logic [1:0][W-1:0]     bk_q,
   output logic [USER_N*W-1:0]   usr_flat
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bk_q[0] <= INIT0;
         bk_q[1] <= INIT1;
      end else if (bk_we) begin
         bk_q[bk_ch] <= bk_wdata;
      end
   end

   for (genvar i = 0; i < USER_N; i++) begin : g_user
      logic [W-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    byte_q <= '0;
         else if (usr_we && usr_addr == UA_W'(i))       byte_q <= usr_wdata;
      end
      assign usr_flat[i*W +: W] = byte_q;
   end

   assert_user_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !usr_we |=> $stable(usr_flat));
   assert_backup_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !bk_we |=> $stable(bk_q));

endmodule

// File: rtl/wps_readback.sv
module wps_readback #(
   parameter int W      = 8,
   parameter int USER_N = 14,
   parameter int SEL_W  = 5
) (
   input  logic [1:0][W-1:0]   wip,
   input  logic [1:0][W-1:0]   bk,
   input  logic [USER_N*W-1:0] usr_flat,
   input  logic [SEL_W-1:0]    sel,
   output logic [W-1:0]        dout
);

   always_comb begin
      dout = '0;
      if (sel == SEL_W'(0)) dout = wip[0];
      if (sel == SEL_W'(1)) dout = wip[1];
      if (sel == SEL_W'(2)) dout = bk[0];
      if (sel == SEL_W'(3)) dout = bk[1];
      for (int i = 0; i < USER_N; i++) begin
         if (sel == SEL_W'(i + 4)) dout = usr_flat[i*W +: W];
      end
   end

endmodule

// File: rtl/wiper_preset_seq.sv
module wiper_preset_seq
   import wps_pkg::*;
#(
   parameter int           W        = 8,
   parameter int           USER_N   = 14,
   parameter int           SAVE_CYC = 20,
   parameter int           ALL_CYC  = 10,
   parameter int           ONE_CYC  = 3,
   parameter logic [W-1:0] INIT0    = 8'h5A,
   parameter logic [W-1:0] INIT1    = 8'hC3,
   localparam int          UA_W     = $clog2(USER_N),
   localparam int          SEL_W    = $clog2(USER_N + 4)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [3:0]       cmd_op,
   input  logic [UA_W-1:0]  cmd_addr,
   input  logic [W-1:0]     cmd_data,
   input  logic             nv_lock,
   input  logic             preset_n,
   input  logic [SEL_W-1:0] rd_sel,
   output logic [W-1:0]     rd_data,
   output logic             ready,
   output logic             cmd_err
);

   localparam int MAX_A   = (SAVE_CYC > ALL_CYC) ? SAVE_CYC : ALL_CYC;
   localparam int MAX_CYC = (MAX_A > ONE_CYC) ? MAX_A : ONE_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [UA_W:0] USER_LIM = (UA_W+1)'(USER_N);

   if (SAVE_CYC < 1 || ALL_CYC < 1 || ONE_CYC < 1) begin : g_bad_cyc
      $error("wiper_preset_seq: busy counts must be at least 1");
   end
   if (USER_N < 2 || W < 1) begin : g_bad_size
      $error("wiper_preset_seq: USER_N must be at least 2 and W at least 1");
   end

   logic             preset_q, preset_fall;
   logic             busy, done, idle, accept;
   logic             start, wr_now, ch_nxt;
   logic [CNT_W-1:0] load;
   job_e             job_nxt, job_q;
   logic             ch_q;
   logic [UA_W-1:0]  addr_q;
   logic [W-1:0]     data_q;
   logic [1:0][W-1:0] wiper, bk;
   logic [USER_N*W-1:0] usr_flat;
   opcode_e          op;

   assign op          = opcode_e'(cmd_op);
   assign preset_fall = preset_q & ~preset_n;
   assign idle        = ~busy;
   assign accept      = cmd_valid & idle & ~preset_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) preset_q <= 1'b1;
      else        preset_q <= preset_n;
   end

   always_comb begin
      start   = 1'b0;
      wr_now  = 1'b0;
      load    = '0;
      job_nxt = JOB_NONE;
      ch_nxt  = cmd_addr[0];
      if (idle && preset_fall) begin
         start   = 1'b1;
         load    = CNT_W'(ALL_CYC);
         job_nxt = JOB_ALL;
      end else if (accept) begin
         case (op)
            OPC_SAVE: if (!nv_lock) begin
               start = 1'b1; load = CNT_W'(SAVE_CYC); job_nxt = JOB_SAVE;
            end
            OPC_USER_WR: if (!nv_lock && ({1'b0, cmd_addr} < USER_LIM)) begin
               start = 1'b1; load = CNT_W'(SAVE_CYC); job_nxt = JOB_USER;
            end
            OPC_RESTORE_ALL: begin
               start = 1'b1; load = CNT_W'(ALL_CYC); job_nxt = JOB_ALL;
            end
            OPC_RESTORE_0, OPC_RESTORE_1: begin
               start = 1'b1; load = CNT_W'(ONE_CYC); job_nxt = JOB_ONE;
               ch_nxt = (op == OPC_RESTORE_1);
            end
            OPC_WIPER_WR: wr_now = 1'b1;
            default: ;
         endcase
      end
   end

   wps_busy_timer #(.CNT_W(CNT_W), .BOOT_LOAD(ALL_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .busy  (busy),
      .done  (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         job_q  <= JOB_ALL;
         ch_q   <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else if (start) begin
         job_q  <= job_nxt;
         ch_q   <= ch_nxt;
         addr_q <= cmd_addr;
         data_q <= cmd_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wiper <= '0;
      end else begin
         for (int c = 0; c < 2; c++) begin
            if (done && (job_q == JOB_ALL || (job_q == JOB_ONE && ch_q == c[0])))
               wiper[c] <= bk[c];
            else if (wr_now && cmd_addr[0] == c[0])
               wiper[c] <= cmd_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 cmd_err <= 1'b0;
      else if (cmd_valid && (busy || preset_fall)) cmd_err <= 1'b1;
   end

   wps_nv_bank #(
      .W(W), .USER_N(USER_N), .UA_W(UA_W), .INIT0(INIT0), .INIT1(INIT1)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .bk_we     (done && job_q == JOB_SAVE),
      .bk_ch     (ch_q),
      .bk_wdata  (wiper[ch_q]),
      .usr_we    (done && job_q == JOB_USER),
      .usr_addr  (addr_q),
      .usr_wdata (data_q),
      .bk_q      (bk),
      .usr_flat  (usr_flat)
   );

   wps_readback #(.W(W), .USER_N(USER_N), .SEL_W(SEL_W)) u_rd (
      .wip      (wiper),
      .bk       (bk),
      .usr_flat (usr_flat),
      .sel      (rd_sel),
      .dout     (rd_data)
   );

   assign ready = ~busy;

   assert_restore_drops_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (cmd_op == 4'd8 || cmd_op == 4'd9 || cmd_op == 4'd10)) |=> !ready);
   assert_locked_keeps_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && nv_lock && (cmd_op == 4'd2 || cmd_op == 4'd3)) |=> ready);
   assert_fast_op_keeps_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !(cmd_op inside {4'd2, 4'd3, 4'd8, 4'd9, 4'd10})) |=> ready);
   assert_preset_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && preset_fall) |=> !ready);
   assert_busy_rejects_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !ready) |=> cmd_err);
   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |=> cmd_err);
   assert_wiper_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(wiper));

endmodule

// File: tb/tb_wiper_preset_seq.sv
`timescale 1ns/1ps
module tb_wiper_preset_seq;

   localparam int SAVE = 20, ALL = 10, ONE = 3;
   localparam logic [7:0] I0 = 8'h5A, I1 = 8'hC3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [3:0] cmd_op = '0, cmd_addr = '0;
   logic [7:0] cmd_data = '0;
   logic       nv_lock = 1'b0, preset_n = 1'b1;
   logic [4:0] rd_sel = '0;
   logic [7:0] rd_data;
   logic       ready, cmd_err;

   int checks = 0, errors = 0;
   string tag = "R1";
   bit started = 0;

   always #4 clk = ~clk;

   wiper_preset_seq #(.SAVE_CYC(SAVE), .ALL_CYC(ALL), .ONE_CYC(ONE),
                      .INIT0(I0), .INIT1(I1)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .nv_lock(nv_lock),
      .preset_n(preset_n), .rd_sel(rd_sel), .rd_data(rd_data),
      .ready(ready), .cmd_err(cmd_err));

   // behavioural reference model
   bit         m_busy, m_err, m_pq, m_ch;
   int         m_cnt, m_job, m_addr;
   logic [7:0] m_data;
   logic [7:0] m_wip [0:1];
   logic [7:0] m_bk  [0:1];
   logic [7:0] m_usr [0:13];

   function automatic logic [7:0] m_read(input int s);
      if (s < 2)  return m_wip[s];
      if (s < 4)  return m_bk[s-2];
      if (s < 18) return m_usr[s-4];
      return 8'h00;
   endfunction

   always @(posedge clk) begin
      bit pf;
      started <= 1;
      if (!rst_n) begin
         m_busy = 1; m_cnt = ALL; m_job = 3; m_err = 0; m_pq = 1;
         m_wip[0] = 0; m_wip[1] = 0; m_bk[0] = I0; m_bk[1] = I1;
         for (int i = 0; i < 14; i++) m_usr[i] = 0;
      end else begin
         pf = m_pq && !preset_n;
         m_pq = preset_n;
         if (cmd_valid && (m_busy || pf)) m_err = 1;
         if (m_busy) begin
            if (m_cnt == 1) begin
               m_busy = 0;
               case (m_job)
                  1: m_bk[m_ch] = m_wip[m_ch];
                  2: m_usr[m_addr] = m_data;
                  3: begin m_wip[0] = m_bk[0]; m_wip[1] = m_bk[1]; end
                  4: m_wip[m_ch] = m_bk[m_ch];
                  default: ;
               endcase
            end else m_cnt--;
         end else if (pf) begin
            m_busy = 1; m_cnt = ALL; m_job = 3;
         end else if (cmd_valid) begin
            m_ch = cmd_addr[0]; m_addr = cmd_addr; m_data = cmd_data;
            case (cmd_op)
               2: if (!nv_lock) begin m_busy = 1; m_cnt = SAVE; m_job = 1; end
               3: if (!nv_lock && cmd_addr < 14) begin m_busy = 1; m_cnt = SAVE; m_job = 2; end
               8: begin m_busy = 1; m_cnt = ALL; m_job = 3; end
               9, 10: begin m_busy = 1; m_cnt = ONE; m_job = 4; m_ch = (cmd_op == 10); end
               11: m_wip[cmd_addr[0]] = cmd_data;
               default: ;
            endcase
         end
      end
   end

   task automatic check(input string t, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (started) begin
         check({tag, " ready"}, ready, !m_busy);
         check({tag, " cmd_err"}, cmd_err, m_err);
         check({tag, " rd_data"}, rd_data, m_read(rd_sel));
      end
   end

   task automatic send(input int op, input int addr, input int data);
      @(posedge clk); #1;
      cmd_valid = 1; cmd_op = op[3:0]; cmd_addr = addr[3:0]; cmd_data = data[7:0];
      @(posedge clk); #1;
      cmd_valid = 0;
   endtask

   task automatic pulse_preset();
      @(posedge clk); #1; preset_n = 0;
      @(posedge clk); #1; preset_n = 1;
   endtask

   task automatic measure(output int n);
      n = 0;
      for (int g = 0; g < 1000; g++) begin
         @(negedge clk);
         if (ready) break;
         n++;
      end
   endtask

   task automatic rd(input int sel, output int v);
      @(posedge clk); #1; rd_sel = sel[4:0];
      @(negedge clk); v = rd_data;
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n, v;
      // R1 reset state and power-on restore
      tag = "R1";
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 ready in reset", ready, 0);
      check("R1 err in reset", cmd_err, 0);
      rd(0, v); check("R1 wiper0 in reset", v, 0);
      rd(2, v); check("R1 backup0 in reset", v, 8'h5A);
      @(posedge clk); #1; rst_n = 1;
      measure(n); check("R1 boot busy length", n, ALL);
      rd(0, v); check("R1 wiper0 after boot", v, 8'h5A);
      rd(1, v); check("R1 wiper1 after boot", v, 8'hC3);

      tag = "R2";
      send(11, 0, 8'h11); measure(n); check("R2 no busy", n, 0);
      rd(0, v); check("R2 wiper0 written", v, 8'h11);

      tag = "R3";
      send(2, 0, 0); measure(n); check("R3 save busy length", n, SAVE);
      rd(2, v); check("R3 backup0 saved", v, 8'h11);

      tag = "R5";
      send(11, 0, 8'h22); send(9, 0, 0); measure(n); check("R5 restore0 length", n, ONE);
      rd(0, v); check("R5 wiper0 restored", v, 8'h11);
      send(11, 1, 8'h44); send(10, 0, 0); measure(n); check("R5 restore1 length", n, ONE);
      rd(1, v); check("R5 wiper1 restored", v, 8'hC3);
      send(11, 0, 8'h66); send(11, 1, 8'h77); send(8, 0, 0); measure(n);
      check("R5 restore-all length", n, ALL);
      rd(0, v); check("R5 wiper0 after all", v, 8'h11);
      rd(1, v); check("R5 wiper1 after all", v, 8'hC3);

      tag = "R4";
      send(3, 13, 8'hAB); measure(n); check("R4 user write length", n, SAVE);
      rd(17, v); check("R4 user13 written", v, 8'hAB);
      send(3, 14, 8'h77); measure(n); check("R4 out-of-range no busy", n, 0);
      rd(4, v); check("R4 user0 untouched", v, 0);
      rd(17, v); check("R4 user13 untouched", v, 8'hAB);

      tag = "R7";
      nv_lock = 1;
      send(11, 0, 8'h99); send(2, 0, 0); measure(n); check("R7 locked save no busy", n, 0);
      rd(2, v); check("R7 backup0 kept", v, 8'h11);
      send(3, 2, 8'h55); measure(n); check("R7 locked user no busy", n, 0);
      rd(6, v); check("R7 user2 kept", v, 0);
      nv_lock = 0;

      tag = "R10";
      send(5, 0, 8'h66); measure(n); check("R10 unknown no busy", n, 0);
      rd(0, v); check("R10 wiper0 kept", v, 8'h99);

      tag = "R6";
      pulse_preset(); measure(n); check("R6 preset busy length", n, ALL);
      rd(0, v); check("R6 wiper0 from backup", v, 8'h11);
      send(11, 0, 8'h33); send(2, 1, 0); pulse_preset(); measure(n);
      measure(n); check("R6 preset during busy dropped", n, 0);
      rd(0, v); check("R6 wiper0 not restored", v, 8'h33);

      tag = "R8";
      check("R8 err clear before", cmd_err, 0);
      send(2, 0, 0); send(11, 0, 8'hEE);
      @(negedge clk); check("R8 err raised", cmd_err, 1);
      measure(n);
      rd(0, v); check("R8 dropped write", v, 8'h33);
      check("R8 err sticky", cmd_err, 1);

      tag = "R9";
      rd(31, v); check("R9 unused select", v, 0);
      rd(3, v);  check("R9 backup1 select", v, 8'hC3);
      rd(2, v);  check("R9 backup0 select", v, 8'h33);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule